// File: doc/BRIEF.md
# Accumulator ALU with Carry

This block is the 8-bit arithmetic and logic engine of an accumulator machine. On each accepted start it takes the accumulator value, a second operand, the B register and the incoming carry, auxiliary-carry and overflow flags. It returns a new accumulator, a new B value and the three flags. Most operations finish in one cycle. Multiply and divide run iteratively, producing a fixed number of result bits per cycle, and write both the accumulator and B. A `start`/`done` handshake with a `busy` indication covers both kinds of operation. Fetching operands and storing the flags are left to the surrounding datapath.

Results and flags are held in output registers until the next operation completes. The caller therefore reads them in the cycle where `done` is high, or in any later cycle before it issues another start. The operation code is the 5-bit value on `op`. Codes 18 to 31 leave every value unchanged.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high and after it falls, before any start, `done`, `busy`, `acc_out`, `breg_out`, `cy_out`, `ac_out` and `ov_out` are all zero.
- R2: Op 0 adds the operand to A, and op 1 adds the operand plus the incoming carry. In both cases `cy_out` is the carry out of bit 7, `ac_out` is the carry out of bit 3, and `ov_out` is the two's-complement overflow.
- R3: Op 2 computes A − operand − carry. `cy_out` is the borrow out of bit 7, `ac_out` is the borrow out of bit 3, and `ov_out` is the two's-complement overflow of the subtraction.
- R4: Op 3 gives A+1 and op 4 gives A−1, both modulo 256. All three flags pass through from their inputs unchanged.
- R5: Op 5 gives A AND operand, op 6 gives A OR operand, op 7 gives A XOR operand, op 8 gives zero and op 9 gives the bitwise inverse of A. All flags pass through.
- R6: Op 10 rotates A left and op 12 rotates A right; the carry passes through untouched. Op 11 rotates A left and op 13 rotates A right through the carry, as a 9-bit ring: the carry enters the vacated bit and receives the bit shifted out. The auxiliary-carry and overflow flags pass through.
- R7: Op 14 exchanges bits 7:4 and bits 3:0 of A. All flags pass through.
- R8: Op 15 (decimal adjust) adds 0x06 when A[3:0] > 9 or the auxiliary carry is set. It then adds 0x60 when the high nibble of that sum is above 9, or the carry is set, or the first step carried out. `cy_out` ends up set if the carry was set or either step carried out. The auxiliary-carry and overflow flags pass through.
- R9: Op 16 puts the low byte of A×B in `acc_out` and the high byte in `breg_out`. It clears `cy_out`, sets `ov_out` exactly when the product exceeds 255, and passes the auxiliary carry through.
- R10: Op 17 puts the quotient A÷B in `acc_out` and the remainder in `breg_out`. It clears `cy_out` and `ov_out` and passes the auxiliary carry through. With B = 0, `ov_out` is set, `cy_out` is cleared, and the A and B results are undefined.
- R11: A start accepted for ops 0–15 raises `done` for one cycle in the next cycle. A start accepted for op 16 or 17 holds `busy` high for the next three cycles, then raises `done` for one cycle in the fourth cycle after the start.
- R12: A start asserted while `busy` is high is ignored. The running multiply or divide completes with its own result and timing, and the ignored start produces no extra `done`.
- R13: For ops 0–15, `breg_out` takes the value of `breg_in` captured with the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| breg_in | input | 8 | B register operand |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary-carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 8 | Accumulator result |
| breg_out | output | 8 | B register result |
| cy_out | output | 1 | Resulting carry flag |
| ac_out | output | 1 | Resulting auxiliary-carry flag |
| ov_out | output | 1 | Resulting overflow flag |

## Verification
Results of a single-cycle operation are due in the cycle right after the start cycle. Multiply and divide results are due four cycles after it, and `busy` is high for the three cycles in between. The bench advances its reference model once per rising edge, using the inputs it drove on the preceding falling edge. It compares every output on each falling edge, so each result is checked in exactly the cycle it falls due and again in every later cycle while the registers hold it. Starts issued during `busy` go through the same model, which must show them as having no effect.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 5;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [DATA_W:0]   word_ext_t;
    typedef logic [NIB_W:0]    nib_ext_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUBB = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_CLR  = 5'd8,
        OP_CPL  = 5'd9,
        OP_RL   = 5'd10,
        OP_RLC  = 5'd11,
        OP_RR   = 5'd12,
        OP_RRC  = 5'd13,
        OP_SWAP = 5'd14,
        OP_DA   = 5'd15,
        OP_MUL  = 5'd16,
        OP_DIV  = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic ac;
        logic ov;
    } flags_t;

    typedef struct packed {
        word_t  acc;
        word_t  bval;
        flags_t fl;
    } alu_res_t;

    function automatic logic is_multi(alu_op_e op);
        return (op == OP_MUL) || (op == OP_DIV);
    endfunction

    // Shared adder: subtraction inverts the operand and the carry-in, then
    // inverts the carries coming out to turn them into borrows.
    function automatic alu_res_t add_sub(word_t a, word_t o, logic use_c,
                                         logic sub, word_t b, flags_t fin);
        word_t     oo;
        logic      cin;
        word_ext_t full;
        nib_ext_t  low;
        alu_res_t  r;
        oo    = sub ? ~o : o;
        cin   = (use_c & fin.c) ^ sub;
        full  = {1'b0, a} + {1'b0, oo} + word_ext_t'(cin);
        low   = {1'b0, a[NIB_W-1:0]} + {1'b0, oo[NIB_W-1:0]} + nib_ext_t'(cin);
        r.acc   = full[DATA_W-1:0];
        r.bval  = b;
        r.fl.c  = full[DATA_W] ^ sub;
        r.fl.ac = low[NIB_W] ^ sub;
        r.fl.ov = (a[DATA_W-1] == oo[DATA_W-1]) && (full[DATA_W-1] != a[DATA_W-1]);
        return r;
    endfunction

    // BCD correction after an addition, low digit first.
    function automatic alu_res_t dec_adjust(word_t a, word_t b, flags_t fin);
        word_ext_t t;
        logic      cy;
        alu_res_t  r;
        t = {1'b0, a};
        if ((a[NIB_W-1:0] > NIB_W'(9)) || fin.ac)
            t = t + word_ext_t'(6);
        cy = fin.c | t[DATA_W];
        t  = {1'b0, t[DATA_W-1:0]};
        if ((t[DATA_W-1:NIB_W] > NIB_W'(9)) || cy)
            t = t + word_ext_t'('h60);
        r.acc   = t[DATA_W-1:0];
        r.bval  = b;
        r.fl.c  = cy | t[DATA_W];
        r.fl.ac = fin.ac;
        r.fl.ov = fin.ov;
        return r;
    endfunction

endpackage

// File: rtl/acc_alu_logic.sv
`timescale 1ns/1ps
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  alu_op_e  op_i,
    input  word_t    a_i,
    input  word_t    o_i,
    input  word_t    b_i,
    input  flags_t   fl_i,
    output alu_res_t res_o
);

    localparam int MSB = DATA_W - 1;

    always_comb begin
        res_o.acc  = a_i;
        res_o.bval = b_i;
        res_o.fl   = fl_i;
        case (op_i)
            OP_ADD:  res_o = add_sub(a_i, o_i, 1'b0, 1'b0, b_i, fl_i);
            OP_ADDC: res_o = add_sub(a_i, o_i, 1'b1, 1'b0, b_i, fl_i);
            OP_SUBB: res_o = add_sub(a_i, o_i, 1'b1, 1'b1, b_i, fl_i);
            OP_INC:  res_o.acc = a_i + word_t'(1);
            OP_DEC:  res_o.acc = a_i - word_t'(1);
            OP_AND:  res_o.acc = a_i & o_i;
            OP_OR:   res_o.acc = a_i | o_i;
            OP_XOR:  res_o.acc = a_i ^ o_i;
            OP_CLR:  res_o.acc = '0;
            OP_CPL:  res_o.acc = ~a_i;
            OP_RL:   res_o.acc = {a_i[MSB-1:0], a_i[MSB]};
            OP_RR:   res_o.acc = {a_i[0], a_i[MSB:1]};
            OP_RLC: begin
                res_o.acc  = {a_i[MSB-1:0], fl_i.c};
                res_o.fl.c = a_i[MSB];
            end
            OP_RRC: begin
                res_o.acc  = {fl_i.c, a_i[MSB:1]};
                res_o.fl.c = a_i[0];
            end
            OP_SWAP: res_o.acc = {a_i[NIB_W-1:0], a_i[MSB:NIB_W]};
            OP_DA:   res_o = dec_adjust(a_i, b_i, fl_i);
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_alu_muldiv.sv
`timescale 1ns/1ps
module acc_alu_muldiv
    import acc_alu_pkg::*;
#(
    parameter int STEP_BITS = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  logic  run_i,
    input  logic  div_i,
    input  word_t a_i,
    input  word_t b_i,
    output word_t lo_o,
    output word_t hi_o
);

    localparam int WIDE_W = 2 * DATA_W;
    typedef logic [WIDE_W-1:0] wide_t;

    wide_t prod_q, prod_s, prod_n;
    word_t shf_q, shf_s, shf_n;      // multiplier bits, or dividend/quotient
    word_t dvs_q, dvs_s;             // multiplicand, or divisor
    word_t rem_q, rem_s, rem_n;
    logic  div_q, div_s;

    // On load the first step works straight from the ports.
    always_comb begin
        if (load_i) begin
            prod_s = '0;
            rem_s  = '0;
            div_s  = div_i;
            shf_s  = div_i ? a_i : b_i;
            dvs_s  = div_i ? b_i : a_i;
        end else begin
            prod_s = prod_q;
            rem_s  = rem_q;
            div_s  = div_q;
            shf_s  = shf_q;
            dvs_s  = dvs_q;
        end
    end

    // Multiply, most significant digit first.
    always_comb begin
        wide_t mcand;
        wide_t digit;
        mcand  = wide_t'(dvs_s);
        digit  = wide_t'(shf_s[DATA_W-1 -: STEP_BITS]);
        prod_n = (prod_s << STEP_BITS) + (mcand * digit);
    end

    // Restoring division, STEP_BITS quotient bits per cycle.
    always_comb begin
        word_ext_t trial;
        word_t     r_t;
        word_t     q_t;
        trial = '0;
        r_t   = rem_s;
        q_t   = shf_s;
        for (int i = 0; i < STEP_BITS; i++) begin
            trial = {r_t, q_t[DATA_W-1]};
            q_t   = q_t << 1;
            if (trial >= {1'b0, dvs_s}) begin
                trial  = trial - {1'b0, dvs_s};
                q_t[0] = 1'b1;
            end
            r_t = trial[DATA_W-1:0];
        end
        rem_n = r_t;
        shf_n = div_s ? q_t : (shf_s << STEP_BITS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            shf_q  <= '0;
            dvs_q  <= '0;
            rem_q  <= '0;
            div_q  <= 1'b0;
        end else if (load_i || run_i) begin
            prod_q <= prod_n;
            shf_q  <= shf_n;
            dvs_q  <= dvs_s;
            rem_q  <= rem_n;
            div_q  <= div_s;
        end
    end

    assign lo_o = div_s ? shf_n : prod_n[DATA_W-1:0];
    assign hi_o = div_s ? rem_n : prod_n[WIDE_W-1:DATA_W];

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int STEP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [DATA_W-1:0] breg_in,
    input  logic              cy_in,
    input  logic              ac_in,
    input  logic              ov_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] breg_out,
    output logic              cy_out,
    output logic              ac_out,
    output logic              ov_out
);

    localparam int MD_STEPS = DATA_W / STEP_BITS;
    localparam int CNT_W    = $clog2(MD_STEPS + 1);

    alu_op_e    op_e;
    flags_t     fl_in;
    alu_res_t   res;
    logic       accept, single_go, multi_go, last_step;
    logic [CNT_W-1:0] cnt_q;
    logic       done_q, div_q, dz_q, ac_hold_q;
    word_t      acc_q, b_q, md_lo, md_hi;
    flags_t     fl_q;

    assign op_e      = alu_op_e'(op);
    assign fl_in     = '{c: cy_in, ac: ac_in, ov: ov_in};
    assign busy      = (cnt_q != '0);
    assign accept    = start && !busy;
    assign multi_go  = accept && is_multi(op_e);
    assign single_go = accept && !is_multi(op_e);
    assign last_step = (cnt_q == CNT_W'(1));

    acc_alu_logic u_logic (
        .op_i  (op_e),
        .a_i   (acc_in),
        .o_i   (opnd_in),
        .b_i   (breg_in),
        .fl_i  (fl_in),
        .res_o (res)
    );

    acc_alu_muldiv #(.STEP_BITS(STEP_BITS)) u_muldiv (
        .clk    (clk),
        .rst    (rst),
        .load_i (multi_go),
        .run_i  (busy),
        .div_i  (op_e == OP_DIV),
        .a_i    (acc_in),
        .b_i    (breg_in),
        .lo_o   (md_lo),
        .hi_o   (md_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            done_q    <= 1'b0;
            div_q     <= 1'b0;
            dz_q      <= 1'b0;
            ac_hold_q <= 1'b0;
            acc_q     <= '0;
            b_q       <= '0;
            fl_q      <= '0;
        end else begin
            done_q <= single_go || last_step;
            if (multi_go) begin
                cnt_q     <= CNT_W'(MD_STEPS - 1);
                div_q     <= (op_e == OP_DIV);
                dz_q      <= (breg_in == '0);
                ac_hold_q <= ac_in;
            end else if (busy) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (single_go) begin
                acc_q <= res.acc;
                b_q   <= res.bval;
                fl_q  <= res.fl;
            end else if (last_step) begin
                acc_q   <= md_lo;
                b_q     <= md_hi;
                fl_q.c  <= 1'b0;
                fl_q.ac <= ac_hold_q;
                fl_q.ov <= div_q ? dz_q : (md_hi != '0);
            end
        end
    end

    assign done     = done_q;
    assign acc_out  = acc_q;
    assign breg_out = b_q;
    assign cy_out   = fl_q.c;
    assign ac_out   = fl_q.ac;
    assign ov_out   = fl_q.ov;

endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] breg_in,
    input logic              cy_in,
    input logic              ac_in,
    input logic              ov_in,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] acc_out,
    input logic [DATA_W-1:0] breg_out,
    input logic              cy_out,
    input logic              ac_out,
    input logic              ov_out
);

    // R11
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !(op == OP_MUL || op == OP_DIV)) |=> (done && !busy));

    // R11
    multi_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (op == OP_MUL || op == OP_DIV)) |=> (busy && !done));

    // R12
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done || ($stable(acc_out) && $stable(breg_out))));

    // R9 R10
    muldiv_carry_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && !cy_out));

    // R13
    breg_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !(op == OP_MUL || op == OP_DIV)) |=> (breg_out == $past(breg_in)));

    // R7
    swap_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == OP_SWAP) |=>
            (acc_out == {$past(acc_in[NIB_W-1:0]), $past(acc_in[DATA_W-1:NIB_W])}));

    // R4
    inc_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == OP_INC) |=>
            (acc_out == word_t'($past(acc_in) + 1'b1) && cy_out == $past(cy_in)
             && ac_out == $past(ac_in) && ov_out == $past(ov_in)));

endmodule

bind acc_alu acc_alu_chk u_chk (.*);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;

    logic       clk = 1'b0;
    logic       rst, start;
    logic [4:0] op;
    logic [7:0] acc_in, opnd_in, breg_in;
    logic       cy_in, ac_in, ov_in;
    logic       busy, done, cy_out, ac_out, ov_out;
    logic [7:0] acc_out, breg_out;

    always #5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .acc_in(acc_in), .opnd_in(opnd_in), .breg_in(breg_in),
        .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
        .busy(busy), .done(done), .acc_out(acc_out), .breg_out(breg_out),
        .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    int    left = 0;
    int    e_done = 0, e_busy = 0;
    int    e_acc = 0, e_b = 0, e_c = 0, e_ac = 0, e_ov = 0, e_dz = 0;
    int    p_acc, p_b, p_c, p_ac, p_ov, p_dz;
    string e_tag = "R1", e_btag = "R1", p_tag = "R9";
    bit    ign_seen = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    task automatic ref_op(input int o, input int a, input int d, input int b,
                          input int c, input int ac, input int ov,
                          output int ra, output int rb, output int rc, output int rac,
                          output int rov, output int rdz, output int lat, output string tg);
        int s, x, cc;
        ra = a; rb = b; rc = c; rac = ac; rov = ov; rdz = 0; lat = 1; tg = "R5";
        case (o)
            0, 1: begin
                cc = (o == 1) ? c : 0;
                s = a + d + cc; ra = s & 255; rc = (s > 255);
                rac = (((a & 15) + (d & 15) + cc) > 15);
                s = sgn(a) + sgn(d) + cc; rov = (s > 127 || s < -128); tg = "R2";
            end
            2: begin
                s = a - d - c; ra = s & 255; rc = (s < 0);
                rac = (((a & 15) - (d & 15) - c) < 0);
                s = sgn(a) - sgn(d) - c; rov = (s > 127 || s < -128); tg = "R3";
            end
            3: begin ra = (a + 1) & 255; tg = "R4"; end
            4: begin ra = (a + 255) & 255; tg = "R4"; end
            5: ra = a & d;
            6: ra = a | d;
            7: ra = a ^ d;
            8: ra = 0;
            9: ra = 255 - a;
            10: begin ra = ((a << 1) | (a >> 7)) & 255; tg = "R6"; end
            11: begin ra = ((a << 1) | c) & 255; rc = a >> 7; tg = "R6"; end
            12: begin ra = (a >> 1) | ((a & 1) << 7); tg = "R6"; end
            13: begin ra = (a >> 1) | (c << 7); rc = a & 1; tg = "R6"; end
            14: begin ra = ((a & 15) << 4) | (a >> 4); tg = "R7"; end
            15: begin
                x = a; cc = c;
                if ((x & 15) > 9 || ac) x = x + 6;
                if (x > 255) cc = 1;
                x = x & 255;
                if ((x >> 4) > 9 || cc) x = x + 'h60;
                if (x > 255) cc = 1;
                ra = x & 255; rc = cc; tg = "R8";
            end
            16: begin
                s = a * b; ra = s & 255; rb = s >> 8; rc = 0; rov = (s > 255);
                lat = 4; tg = "R9";
            end
            17: begin
                rc = 0; lat = 4; tg = "R10";
                if (b == 0) begin rov = 1; rdz = 1; end
                else begin ra = a / b; rb = a % b; rov = 0; end
            end
            default: tg = "R5";
        endcase
    endtask

    task automatic compare_all(input string force_tag);
        string tt, dt, bt;
        tt = (force_tag != "") ? force_tag : (ign_seen ? "R12" : "R11");
        dt = (force_tag != "") ? force_tag : (ign_seen ? "R12" : e_tag);
        bt = (force_tag != "") ? force_tag : (ign_seen ? "R12" : e_btag);
        chk(tt, "done", int'(done), e_done);
        chk(tt, "busy", int'(busy), e_busy);
        if (!e_dz) begin
            chk(dt, "acc_out", int'(acc_out), e_acc);
            chk(bt, "breg_out", int'(breg_out), e_b);
        end
        chk(dt, "cy_out", int'(cy_out), e_c);
        chk(dt, "ac_out", int'(ac_out), e_ac);
        chk(dt, "ov_out", int'(ov_out), e_ov);
    endtask

    // Drive at a falling edge, advance the model for the coming rising edge,
    // then compare at the next falling edge.
    task automatic cycle(input bit st, input int o, input int a, input int d, input int b,
                         input int c, input int ac, input int ov);
        int ra, rb, rc, rac, rov, rdz, lat;
        string tg;
        start = st; op = o[4:0]; acc_in = a[7:0]; opnd_in = d[7:0]; breg_in = b[7:0];
        cy_in = c[0]; ac_in = ac[0]; ov_in = ov[0];
        if (left > 0) begin
            if (st) ign_seen = 1;
            left--;
            if (left == 0) begin
                e_done = 1; e_acc = p_acc; e_b = p_b; e_c = p_c; e_ac = p_ac;
                e_ov = p_ov; e_dz = p_dz; e_tag = p_tag; e_btag = p_tag;
            end else e_done = 0;
        end else if (st) begin
            ref_op(o, a, d, b, c, ac, ov, ra, rb, rc, rac, rov, rdz, lat, tg);
            if (lat == 1) begin
                e_done = 1; e_acc = ra; e_b = rb; e_c = rc; e_ac = rac; e_ov = rov;
                e_dz = 0; e_tag = tg; e_btag = "R13";
            end else begin
                left = lat - 1; e_done = 0;
                p_acc = ra; p_b = rb; p_c = rc; p_ac = rac; p_ov = rov; p_dz = rdz; p_tag = tg;
            end
        end else e_done = 0;
        e_busy = (left > 0);
        @(negedge clk);
        compare_all("");
        if (e_done) ign_seen = 0;
    endtask

    task automatic run_op(input int o, input int a, input int d, input int b,
                          input int c, input int ac, input int ov);
        cycle(1, o, a, d, b, c, ac, ov);
        while (left > 0) cycle(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst = 1; start = 0; op = 0; acc_in = 0; opnd_in = 0; breg_in = 0;
        cy_in = 0; ac_in = 0; ov_in = 0;
        repeat (3) @(negedge clk);
        compare_all("R1");           // R1 during reset
        rst = 0;
        cycle(0, 0, 0, 0, 0, 0, 0, 0);  // R1 after release, idle

        // R2 add corners
        run_op(0, 'hFF, 'h01, 'h33, 0, 0, 0);
        run_op(0, 'h7F, 'h01, 'h33, 0, 0, 0);
        run_op(1, 'h0E, 'h01, 'h10, 1, 0, 0);
        // R3 subtract with borrow
        run_op(2, 'h00, 'h01, 'h44, 0, 0, 0);
        run_op(2, 'h80, 'h01, 'h44, 0, 0, 0);
        run_op(2, 'h50, 'h20, 'h44, 1, 0, 1);
        // R4 increment / decrement wrap, flags pass
        run_op(3, 'hFF, 0, 'h12, 1, 1, 0);
        run_op(4, 'h00, 0, 'h12, 0, 1, 1);
        // R5 logic
        run_op(5, 'hF0, 'h3C, 1, 1, 0, 1);
        run_op(6, 'hF0, 'h0C, 2, 0, 1, 0);
        run_op(7, 'hAA, 'hFF, 3, 1, 1, 1);
        run_op(8, 'h5A, 0, 4, 0, 0, 0);
        run_op(9, 'h5A, 0, 5, 1, 0, 0);
        // R6 rotates
        run_op(10, 'h81, 0, 6, 0, 0, 0);
        run_op(11, 'h81, 0, 6, 0, 0, 0);
        run_op(12, 'h01, 0, 6, 0, 1, 0);
        run_op(13, 'h02, 0, 6, 1, 0, 0);
        // R7 swap
        run_op(14, 'h3C, 0, 7, 1, 1, 1);
        // R8 decimal adjust
        run_op(15, 'h41, 0, 8, 0, 1, 0);
        run_op(15, 'h9A, 0, 8, 0, 0, 0);
        run_op(15, 'h12, 0, 8, 1, 0, 0);
        // R9 multiply
        run_op(16, 'hFF, 0, 'hFF, 1, 1, 0);
        run_op(16, 'h10, 0, 'h0F, 1, 0, 1);
        // R10 divide, including divide by zero
        run_op(17, 'hFB, 0, 'h12, 1, 1, 0);
        run_op(17, 'h07, 0, 'h09, 0, 0, 1);
        run_op(17, 'h55, 0, 'h00, 1, 0, 0);
        run_op(17, 'hFF, 0, 'h01, 0, 0, 0);
        // R12 starts during busy are ignored
        cycle(1, 16, 'h0D, 0, 'h0B, 0, 0, 0);
        cycle(1, 0, 'h11, 'h22, 'h33, 0, 0, 0);
        cycle(1, 8, 'h11, 'h22, 'h33, 1, 1, 1);
        cycle(1, 17, 'h11, 'h22, 'h33, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0, 0);

        // mixed random traffic, starts land freely during busy
        for (int i = 0; i < 600; i++) begin
            cycle(($urandom_range(0, 3) != 0), $urandom_range(0, 17),
                  $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
                  $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
        end
        while (left > 0) cycle(0, 0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule